// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge-Triggered Interrupts

This block manages sixteen general-purpose pins, grouped as two banks of eight, behind a byte-wide register port. Each pin has two control bytes. The drive byte sets the direction, push-pull or open-drain drive, the pull configuration and the output value. The sense byte holds a two-bit edge selector and returns the pin's current synchronized level. Pin n sits in bank n/8, at bit position n mod 8.

Every pin input passes through a two-flop synchronizer. A selected transition on the synchronized level sets that pin's bit in its bank's pending byte. Software clears pending bits by writing ones to that byte. A per-bank active mask gates the pending bits onto a single interrupt line. A second per-bank mask for the sleep state and a panel byte are plain storage. The register port is combinational on reads and takes writes on the clock edge while the write strobe is high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The drive byte of pin n is at 0x2B+n for n<8 and at 0x3B+(n-8) for n>=8. It stores bits [5:0]: bit 5 direction (1 = output), bit 4 open-drain (1) or push-pull (0), bit 3 pull enable, bits [2:1] pull select, bit 0 output value. Bits [7:6] read as 0.
- R2: The sense byte of pin n is at 0x33+n for n<8 and at 0x43+(n-8) for n>=8. Bits [2:1] store the edge selector. Bit 0 reads the pin level after a two-flop synchronizer. Bits [7:3] read as 0, and a write to bit 0 has no effect.
- R3: Each pin drives pin_out with its output-value bit. pin_oe is 1 only when direction is output and the drive is either push-pull or has an output value of 0.
- R4: Edge selector codes are 0 = off, 1 = falling, 2 = rising and 3 = both. A matching transition on pin_in sets the pin's pending bit no more than three clock edges after the change. A non-matching transition leaves the bit unchanged.
- R5: A pin's mask bit does not stop a detected edge from setting its pending bit.
- R6: The pending bytes are at 0x0B (bank 0) and 0x0C (bank 1), bit index n mod 8. Writing a 1 clears that bit, and writing a 0 leaves it unchanged.
- R7: If an edge and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R8: irq is 1 exactly when some pin has both its pending bit set and its active-mask bit clear. The active masks are at 0x19 (bank 0) and 0x1A (bank 1), and 1 means masked.
- R9: The sleep masks at 0x1B and 0x1C read back what was written and have no effect on irq.
- R10: The panel byte at 0x52 reads back what was written.
- R11: After reset, every register, pin_oe, pin_out and irq are 0.
- R12: A read from any unmapped address returns 0x00. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Random pin vectors are applied against random edge selectors. This separates the four selector codes, because one transition must set a bit under one code and leave it alone under another. Random clearing writes and random mask bytes are mixed in. They show that a clear touches only the bits written as one, that a masked pin still records its edge, and that only the active mask gates irq. Directed cases cover the following:
- a clear that lands in the same cycle as a new edge, which tells set-priority apart from clear-priority;
- open-drain drive with output value 1 against value 0;
- writes to unmapped addresses next to the mapped ranges;
- sleep-mask writes, which must leave irq unchanged.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 2;
    localparam int NUM_PINS  = BANK_W * NUM_BANKS;

    // Register base addresses; the per-pin blocks are contiguous per bank
    localparam int DRV_BASE_B0   = 'h2B;
    localparam int DRV_BASE_B1   = 'h3B;
    localparam int SNS_BASE_B0   = 'h33;
    localparam int SNS_BASE_B1   = 'h43;
    localparam int PEND_BASE     = 'h0B;
    localparam int AMASK_BASE    = 'h19;
    localparam int SMASK_BASE    = 'h1B;
    localparam int PANEL_ADDR    = 'h52;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    // Field order matches the drive byte bit positions 5..0
    typedef struct packed {
        logic       dir_out;
        logic       open_drain;
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       out_val;
    } drive_cfg_t;

    function automatic logic [ADDR_W-1:0] drive_addr(input int pin);
        return (pin < BANK_W) ? ADDR_W'(DRV_BASE_B0 + pin)
                              : ADDR_W'(DRV_BASE_B1 + pin - BANK_W);
    endfunction

    function automatic logic [ADDR_W-1:0] sense_addr(input int pin);
        return (pin < BANK_W) ? ADDR_W'(SNS_BASE_B0 + pin)
                              : ADDR_W'(SNS_BASE_B1 + pin - BANK_W);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH-1:0]      pin_in,
    input  logic [WIDTH-1:0][1:0] edge_sel,
    output logic [WIDTH-1:0]      level,
    output logic [WIDTH-1:0]      edge_hit
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sync;

    for (genvar i = 0; i < WIDTH; i++) begin : g_edge
        logic rise_w, fall_w;
        assign rise_w = st_q.sync[i] & ~st_q.prev[i];
        assign fall_w = ~st_q.sync[i] & st_q.prev[i];
        always_comb begin
            unique case (edge_sel_e'(edge_sel[i]))
                EDGE_FALL: edge_hit[i] = fall_w;
                EDGE_RISE: edge_hit[i] = rise_w;
                EDGE_BOTH: edge_hit[i] = rise_w | fall_w;
                default:   edge_hit[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] edge_hit,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_data,
    input  logic [WIDTH-1:0] act_mask,
    output logic [WIDTH-1:0] pending,
    output logic             bank_irq
);

    typedef struct packed {
        logic [WIDTH-1:0] pend;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        logic [WIDTH-1:0] clr_bits;
        clr_bits  = clr_we ? clr_data : '0;
        st_d      = st_q;
        // a fresh edge outranks a clear of the same bit
        st_d.pend = (st_q.pend & ~clr_bits) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending  = st_q.pend;
    assign bank_irq = |(st_q.pend & ~act_mask);

    // R4 R5 R7
    edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((pending & $past(edge_hit)) == $past(edge_hit)));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(edge_hit)) == '0));

    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pending & $past(clr_data & ~edge_hit)) == '0));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    typedef struct packed {
        drive_cfg_t [NUM_PINS-1:0]             drv;
        logic       [NUM_PINS-1:0][1:0]        esel;
        logic       [NUM_BANKS-1:0][BANK_W-1:0] amask;
        logic       [NUM_BANKS-1:0][BANK_W-1:0] smask;
        logic       [DATA_W-1:0]               panel;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_PINS-1:0]               level_w;
    logic [NUM_PINS-1:0]               edge_hit_w;
    logic [NUM_BANKS-1:0]              clr_we_w;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  pend_w;
    logic [NUM_BANKS-1:0]              bank_irq_w;

    gpio_pin_sync #(.WIDTH(NUM_PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .edge_sel (r_q.esel),
        .level    (level_w),
        .edge_hit (edge_hit_w)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign clr_we_w[b] = reg_wr && (reg_addr == ADDR_W'(PEND_BASE + b));
        gpio_irq_bank #(.WIDTH(BANK_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_hit (edge_hit_w[b*BANK_W +: BANK_W]),
            .clr_we   (clr_we_w[b]),
            .clr_data (reg_wdata[BANK_W-1:0]),
            .act_mask (r_q.amask[b]),
            .pending  (pend_w[b]),
            .bank_irq (bank_irq_w[b])
        );
    end

    assign irq = |bank_irq_w;

    // Register write path
    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (reg_addr == drive_addr(p)) r_d.drv[p]  = drive_cfg_t'(reg_wdata[5:0]);
                if (reg_addr == sense_addr(p)) r_d.esel[p] = reg_wdata[2:1];
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (reg_addr == ADDR_W'(AMASK_BASE + b)) r_d.amask[b] = reg_wdata[BANK_W-1:0];
                if (reg_addr == ADDR_W'(SMASK_BASE + b)) r_d.smask[b] = reg_wdata[BANK_W-1:0];
            end
            if (reg_addr == ADDR_W'(PANEL_ADDR)) r_d.panel = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Register read path
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (reg_addr == drive_addr(p)) reg_rdata = {2'b00, r_q.drv[p]};
            if (reg_addr == sense_addr(p)) reg_rdata = {5'b0, r_q.esel[p], level_w[p]};
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == ADDR_W'(PEND_BASE + b))  reg_rdata = pend_w[b];
            if (reg_addr == ADDR_W'(AMASK_BASE + b)) reg_rdata = r_q.amask[b];
            if (reg_addr == ADDR_W'(SMASK_BASE + b)) reg_rdata = r_q.smask[b];
        end
        if (reg_addr == ADDR_W'(PANEL_ADDR)) reg_rdata = r_q.panel;
    end

    // Pad drive
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        assign pin_out[p] = r_q.drv[p].out_val;
        assign pin_oe[p]  = r_q.drv[p].dir_out &
                            (~r_q.drv[p].open_drain | ~r_q.drv[p].out_val);
    end

    // R10 R12
    panel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(PANEL_ADDR)) |=> $stable(r_q.panel));

    // R9
    smask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(r_q.smask));

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [15:0] pin_in;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    always #4 clk = ~clk;   // 125 MHz

    gpio_bank_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model
    logic [5:0]  m_drv   [16];
    logic [1:0]  m_esel  [16];
    logic [7:0]  m_amask [2];
    logic [7:0]  m_smask [2];
    logic [7:0]  m_pend  [2];
    logic [7:0]  m_panel;
    logic [15:0] m_pins;

    function automatic logic [7:0] a_drv(int p);
        return (p < 8) ? 8'(8'h2B + p) : 8'(8'h3B + p - 8);
    endfunction
    function automatic logic [7:0] a_sns(int p);
        return (p < 8) ? 8'(8'h33 + p) : 8'(8'h43 + p - 8);
    endfunction
    function automatic bit edge_match(logic [1:0] sel, bit was, bit now);
        if (was == now) return 0;
        case (sel)
            2'd1: return !now;
            2'd2: return now;
            2'd3: return 1;
            default: return 0;
        endcase
    endfunction
    function automatic bit exp_irq();
        return |(m_pend[0] & ~m_amask[0]) | |(m_pend[1] & ~m_amask[1]);
    endfunction
    function automatic bit exp_oe(int p);
        return m_drv[p][5] & (~m_drv[p][4] | ~m_drv[p][0]);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        // update model
        for (int p = 0; p < 16; p++) begin
            if (a == a_drv(p)) m_drv[p]  = d[5:0];
            if (a == a_sns(p)) m_esel[p] = d[2:1];
        end
        for (int b = 0; b < 2; b++) begin
            if (a == 8'(8'h0B + b)) m_pend[b]  = m_pend[b] & ~d;
            if (a == 8'(8'h19 + b)) m_amask[b] = d;
            if (a == 8'(8'h1B + b)) m_smask[b] = d;
        end
        if (a == 8'h52) m_panel = d;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_pins(logic [15:0] v);
        logic [15:0] was;
        @(negedge clk);
        was = m_pins;
        pin_in = v;
        repeat (4) @(negedge clk);
        for (int p = 0; p < 16; p++)
            if (edge_match(m_esel[p], was[p], v[p])) m_pend[p/8][p%8] = 1'b1;
        m_pins = v;
    endtask

    task automatic check_pend(string req);
        logic [7:0] d;
        rd(8'h0B, d); chk({req, " pend0"}, d, m_pend[0]);
        rd(8'h0C, d); chk({req, " pend1"}, d, m_pend[1]);
        chk("R8 irq", irq, exp_irq());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0017));
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; pin_in = '0;
        for (int p = 0; p < 16; p++) begin m_drv[p] = '0; m_esel[p] = '0; end
        for (int b = 0; b < 2; b++) begin m_amask[b] = '0; m_smask[b] = '0; m_pend[b] = '0; end
        m_panel = '0; m_pins = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11 reset state
        chk("R11 irq", irq, 0);
        chk("R11 pin_oe", pin_oe, 0);
        chk("R11 pin_out", pin_out, 0);
        rd(8'h52, d); chk("R11 panel", d, 0);
        rd(8'h19, d); chk("R11 amask0", d, 0);
        rd(8'h1C, d); chk("R11 smask1", d, 0);
        rd(a_drv(9), d); chk("R11 drive9", d, 0);
        check_pend("R11");

        // R1 R3 drive bytes and pad drive, all pins
        for (int p = 0; p < 16; p++) wr(a_drv(p), 8'($urandom));
        for (int p = 0; p < 16; p++) begin
            rd(a_drv(p), d); chk("R1 drive readback", d, {2'b00, m_drv[p]});
            chk("R3 pin_oe", pin_oe[p], exp_oe(p));
            chk("R3 pin_out", pin_out[p], m_drv[p][0]);
        end
        // R3 open-drain directed: value 1 releases, value 0 drives
        wr(a_drv(2), 8'h31); chk("R3 od high oe", pin_oe[2], 0);
        wr(a_drv(2), 8'h30); chk("R3 od low oe", pin_oe[2], 1);
        wr(a_drv(2), 8'h21); chk("R3 pp high oe", pin_oe[2], 1);
        wr(a_drv(2), 8'h01); chk("R3 input oe", pin_oe[2], 0);

        // R9 R10 plain storage
        wr(8'h52, 8'hA5); rd(8'h52, d); chk("R10 panel", d, 8'hA5);
        wr(8'h1B, 8'h3C); rd(8'h1B, d); chk("R9 smask0", d, 8'h3C);
        wr(8'h1C, 8'hC3); rd(8'h1C, d); chk("R9 smask1", d, 8'hC3);

        // R12 unmapped addresses
        foreach (d[i]) ;
        wr(8'h00, 8'hFF); wr(8'h4B, 8'hFF); wr(8'h53, 8'hFF);
        wr(8'h1D, 8'hFF); wr(8'h0A, 8'hFF); wr(8'h2A, 8'hFF);
        rd(8'h00, d); chk("R12 read 00", d, 0);
        rd(8'h4B, d); chk("R12 read 4B", d, 0);
        rd(8'h1D, d); chk("R12 read 1D", d, 0);
        rd(8'h52, d); chk("R12 panel kept", d, m_panel);
        rd(8'h1B, d); chk("R12 smask0 kept", d, m_smask[0]);
        rd(8'h19, d); chk("R12 amask0 kept", d, m_amask[0]);
        rd(a_drv(15), d); chk("R12 drive15 kept", d, {2'b00, m_drv[15]});

        // R2 sense byte: bit0 write ignored, level readback
        wr(a_sns(10), 8'hFF);
        rd(a_sns(10), d); chk("R2 sense readback", d, {5'b0, m_esel[10], m_pins[10]});
        wr(a_sns(10), 8'h00);
        set_pins(16'h0401);
        rd(a_sns(10), d); chk("R2 level pin10", d, 8'h01);
        rd(a_sns(0), d);  chk("R2 level pin0", d, 8'h01);
        set_pins(16'h0000);
        check_pend("R4 off");

        // R7 collision: pin 3 rising, clear lands with the edge
        wr(a_sns(3), 8'h04);
        @(negedge clk); pin_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 8'h0B; reg_wdata = 8'h08; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        m_pins[3] = 1'b1; m_pend[0][3] = 1'b1;
        check_pend("R7 set wins");
        wr(8'h0B, 8'h08);
        check_pend("R6 clear");

        // R5 R8 masked pin still pends, irq gated by active mask
        wr(8'h1A, 8'h02); wr(a_sns(9), 8'h06);
        set_pins(m_pins | 16'h0200);
        check_pend("R5 masked pend");
        chk("R8 masked irq", irq, 0);
        wr(8'h1C, 8'h00); chk("R9 smask no irq effect", irq, 0);
        wr(8'h1A, 8'h00); chk("R8 unmasked irq", irq, 1);
        wr(8'h0C, 8'h02); check_pend("R6 clear bank1");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: wr(a_sns(int'($urandom % 16)), 8'($urandom));
                1: set_pins(16'($urandom));
                2: wr(8'(8'h0B + ($urandom % 2)), 8'($urandom));
                3: wr(8'(8'h19 + ($urandom % 2)), 8'($urandom));
                default: wr(8'(8'h1B + ($urandom % 2)), 8'($urandom));
            endcase
            check_pend("R4 R6 random");
        end

        finish_run();
    end

endmodule